// File: doc/BRIEF.md
# Software Write-Protect Sequence Detector

This block sits beside the write controller of a byte-writable nonvolatile array and inspects every decoded write (address, data byte, one-cycle strobe). It tracks multi-write key sequences. One key sequence arms protection, or grants a single load window while protection is on. A longer key sequence lifts protection. For every strobed write it decides, in the same cycle, one of three outcomes. The byte may be passed on to the array. The byte may be swallowed as part of a key sequence. Or the write may be refused, in which case the controller is told to run an empty, full-length programming period.

A change of protection never takes effect when its key sequence completes. It is held pending and committed only when the controller reports the end of its programming period. The protection flag and the pending change are cleared only by the power-on reset. A separate soft reset returns just the sequence tracker to its idle step.

Top module: `swp_guard`

## Requirements
- R1: After `por_n` is released, `prot_on` equals the parameter `PROT_INIT` (default 0), and no output pulses without a strobe.
- R2: While unprotected, a strobed write that is not part of a key sequence raises `wr_accept` in the same cycle, with `dummy_start` low.
- R3: The arm/authorise key (data 0xAA at address `CMD_ADDR_A` = 0x5555, then 0x55 at `CMD_ADDR_B` = 0x2AAA, then 0xA0 at 0x5555) is consumed: all three writes leave both `wr_accept` and `dummy_start` low. `prot_on` rises only at the clock edge that samples the next `prog_done` pulse.
- R4: While protected and outside a load window, a strobed write raises `dummy_start` in the same cycle and leaves `wr_accept` low.
- R5: Once the arm/authorise key completes, every following write is accepted, even while protected. This lasts until the strobe gap limit closes the window. After that, writes are judged by R4 again.
- R6: The lift key (0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555) is consumed. It also opens a load window. `prot_on` falls at the edge that samples the next `prog_done`.
- R7: A write that does not match the next expected key step returns the tracker to idle. That same write is then accepted if unprotected, or refused with `dummy_start` if protected.
- R8: A key step or window write arriving `LOAD_GAP_CYC` cycles after the previous strobe continues the sequence. A gap of `LOAD_GAP_CYC`+1 cycles aborts it to idle.
- R9: `soft_rst_n` low for one cycle returns the tracker to idle. It leaves `prot_on` and any pending protection change untouched.
- R10: `prog_done` with no pending change leaves `prot_on` unchanged. `wr_accept` and `dummy_start` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; initialises everything |
| soft_rst_n | input | 1 | Soft reset of the sequence tracker, active low |
| wr_stb | input | 1 | One-cycle strobe for a decoded write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| prog_done | input | 1 | End of the controller's programming period |
| prot_on | output | 1 | Persistent protection flag |
| wr_accept | output | 1 | Strobed byte goes to the array |
| dummy_start | output | 1 | Strobed write refused; start an empty programming period |

## Verification
The embedded assertions check several rules on every cycle. The protection flag moves only after a `prog_done`. The accept and refuse pulses are exclusive and need a strobe. A load window is entered only from the final step of a key. A mismatched or timed-out step always lands the tracker in idle. The bench's scenarios are the only evidence for the sequence-level behaviour. This covers the exact key byte values, the one-cycle boundary of the gap limit, and the page writes accepted after authorisation. It also covers a pending change that survives a soft reset and is committed later.

// File: rtl/swp_pkg.sv
package swp_pkg;

  localparam int DATA_W = 8;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;
  localparam logic [DATA_W-1:0] OP_AUTH    = 8'hA0;
  localparam logic [DATA_W-1:0] OP_PRELIFT = 8'h80;
  localparam logic [DATA_W-1:0] OP_LIFT    = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_L3,
    ST_L4,
    ST_L5,
    ST_AUTH
  } step_t;

  // Step reached by one strobed write; ST_IDLE signals a mismatch.
  function automatic step_t next_step(input step_t cur, input logic at_a,
                                      input logic at_b, input logic [DATA_W-1:0] d);
    step_t n;
    n = ST_IDLE;
    case (cur)
      ST_IDLE: if (at_a && d == KEY_FIRST)  n = ST_K1;
      ST_K1:   if (at_b && d == KEY_SECOND) n = ST_K2;
      ST_K2: begin
        if (at_a && d == OP_AUTH)         n = ST_AUTH;
        else if (at_a && d == OP_PRELIFT) n = ST_L3;
      end
      ST_L3:   if (at_a && d == KEY_FIRST)  n = ST_L4;
      ST_L4:   if (at_b && d == KEY_SECOND) n = ST_L5;
      ST_L5:   if (at_a && d == OP_LIFT)    n = ST_AUTH;
      ST_AUTH: n = ST_AUTH;
      default: n = ST_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/swp_gap_timer.sv
module swp_gap_timer #(
  parameter int GAP_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic stb,
  output logic expire
);
  localparam int CW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(GAP_CYC - 1);

  logic [CW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                gap_cnt <= '0;
    else if (stb || !run)      gap_cnt <= '0;
    else if (gap_cnt != LAST)  gap_cnt <= gap_cnt + 1'b1;
  end

  assign expire = run && !stb && (gap_cnt == LAST);

  // R8: the count restarts after every strobe
  assert_gap_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && run) |=> (gap_cnt == '0));

endmodule

// File: rtl/swp_seq_match.sv
module swp_seq_match
  import swp_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter logic [ADDR_W-1:0] CMD_ADDR_A = 'h5555,
  parameter logic [ADDR_W-1:0] CMD_ADDR_B = 'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              expire,
  output logic              busy,
  output logic              consume,
  output logic              in_auth,
  output logic              req_on,
  output logic              req_off
);
  step_t step_q, step_nx;

  assign step_nx = next_step(step_q, addr == CMD_ADDR_A, addr == CMD_ADDR_B, data);

  always_ff @(posedge clk) begin
    if (!rst_n)       step_q <= ST_IDLE;
    else if (stb)     step_q <= step_nx;
    else if (expire)  step_q <= ST_IDLE;
  end

  assign busy    = (step_q != ST_IDLE);
  assign in_auth = (step_q == ST_AUTH);
  assign consume = stb && !in_auth && (step_nx != ST_IDLE);
  assign req_on  = stb && (step_q == ST_K2) && (step_nx == ST_AUTH);
  assign req_off = stb && (step_q == ST_L5) && (step_nx == ST_AUTH);

  // R8: an expired gap with no strobe drops the tracker to idle
  assert_gap_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && expire && !stb) |=> (step_q == ST_IDLE));

  // R5: a load window opens only from the last step of a key
  assert_auth_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_auth && $past(step_q) != ST_AUTH) |->
      ($past(step_q) == ST_K2 || $past(step_q) == ST_L5));

  // R7: a non-matching write outside a window returns to idle
  assert_mismatch_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !consume && !in_auth) |=> (step_q == ST_IDLE));

endmodule

// File: rtl/swp_prot_state.sv
module swp_prot_state #(
  parameter logic PROT_INIT = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic req_on,
  input  logic req_off,
  input  logic prog_done,
  output logic prot
);
  logic pend_v, pend_val;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      prot     <= PROT_INIT;
      pend_v   <= 1'b0;
      pend_val <= 1'b0;
    end else begin
      if (prog_done && pend_v) begin
        prot   <= pend_val;
        pend_v <= 1'b0;
      end
      if (req_on || req_off) begin
        pend_v   <= 1'b1;
        pend_val <= req_on;
      end
    end
  end

  // R10: the flag moves only at a programming-period end
  assert_commit_only_R10: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(prot) |-> $past(prog_done));

  // R3: the arm and lift requests never coincide
  assert_req_excl_R3: assert property (@(posedge clk) disable iff (!por_n)
    !(req_on && req_off));

endmodule

// File: rtl/swp_guard.sv
module swp_guard
  import swp_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter logic [ADDR_W-1:0] CMD_ADDR_A = 'h5555,
  parameter logic [ADDR_W-1:0] CMD_ADDR_B = 'h2AAA,
  parameter int LOAD_GAP_CYC = 16,
  parameter logic PROT_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_done,
  output logic              prot_on,
  output logic              wr_accept,
  output logic              dummy_start
);
  logic match_rst_n, busy, expire, consume, in_auth, req_on, req_off;

  assign match_rst_n = por_n && soft_rst_n;

  swp_gap_timer #(.GAP_CYC(LOAD_GAP_CYC)) gap_i (
    .clk(clk), .rst_n(match_rst_n), .run(busy), .stb(wr_stb), .expire(expire)
  );

  swp_seq_match #(.ADDR_W(ADDR_W), .CMD_ADDR_A(CMD_ADDR_A), .CMD_ADDR_B(CMD_ADDR_B)) match_i (
    .clk(clk), .rst_n(match_rst_n), .stb(wr_stb), .addr(wr_addr), .data(wr_data),
    .expire(expire), .busy(busy), .consume(consume), .in_auth(in_auth),
    .req_on(req_on), .req_off(req_off)
  );

  swp_prot_state #(.PROT_INIT(PROT_INIT)) prot_i (
    .clk(clk), .por_n(por_n), .req_on(req_on), .req_off(req_off),
    .prog_done(prog_done), .prot(prot_on)
  );

  assign wr_accept   = wr_stb && !consume && (in_auth || !prot_on);
  assign dummy_start = wr_stb && !consume && !in_auth && prot_on;

  // R10: a write never gets both outcomes
  assert_outcome_excl_R10: assert property (@(posedge clk) disable iff (!por_n)
    !(wr_accept && dummy_start));

  // R1: no outcome pulse without a strobe
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!por_n)
    !wr_stb |-> (!wr_accept && !dummy_start));

  // R4: a refused write happens only under protection
  assert_refuse_prot_R4: assert property (@(posedge clk) disable iff (!por_n)
    dummy_start |-> prot_on);

endmodule

// File: tb/swp_guard_tb_top.sv
`timescale 1ns/1ps
module swp_guard_tb_top;
  localparam int GAP = 16;
  localparam int NV  = 29;

  logic clk = 1'b0, por_n = 1'b0, soft_rst_n = 1'b1, wr_stb = 1'b0, prog_done = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic prot_on, wr_accept, dummy_start;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  swp_guard #(.LOAD_GAP_CYC(GAP)) dut_i (
    .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .prog_done(prog_done),
    .prot_on(prot_on), .wr_accept(wr_accept), .dummy_start(dummy_start)
  );

  // {op[1:0], addr[14:0], data[7:0], acc, dum, prot, req[3:0]}
  // op 0 = write, 1 = prog_done pulse, 2 = idle past the gap limit
  localparam logic [31:0] VEC [0:NV-1] = '{
    {2'd0, 15'h0100, 8'h11, 3'b100, 4'd2},  // R2 plain write
    {2'd0, 15'h5555, 8'hAA, 3'b000, 4'd3},  // R3 key
    {2'd0, 15'h2AAA, 8'h55, 3'b000, 4'd3},
    {2'd0, 15'h5555, 8'hA0, 3'b000, 4'd3},
    {2'd0, 15'h0040, 8'h33, 3'b100, 4'd5},  // R5 window data
    {2'd1, 15'h0000, 8'h00, 3'b001, 4'd3},  // R3 commit
    {2'd0, 15'h0041, 8'h44, 3'b101, 4'd5},
    {2'd2, 15'h0000, 8'h00, 3'b001, 4'd5},
    {2'd0, 15'h0100, 8'h22, 3'b011, 4'd4},  // R4 refused
    {2'd0, 15'h5555, 8'hAA, 3'b001, 4'd7},
    {2'd0, 15'h1234, 8'h55, 3'b011, 4'd7},  // R7 mismatch, protected
    {2'd0, 15'h5555, 8'hAA, 3'b001, 4'd5},
    {2'd0, 15'h2AAA, 8'h55, 3'b001, 4'd5},
    {2'd0, 15'h5555, 8'hA0, 3'b001, 4'd5},
    {2'd0, 15'h0200, 8'h77, 3'b101, 4'd5},  // R5 authorised write
    {2'd2, 15'h0000, 8'h00, 3'b001, 4'd5},
    {2'd0, 15'h0200, 8'h78, 3'b011, 4'd5},  // R5 window closed
    {2'd0, 15'h5555, 8'hAA, 3'b001, 4'd6},  // R6 lift key
    {2'd0, 15'h2AAA, 8'h55, 3'b001, 4'd6},
    {2'd0, 15'h5555, 8'h80, 3'b001, 4'd6},
    {2'd0, 15'h5555, 8'hAA, 3'b001, 4'd6},
    {2'd0, 15'h2AAA, 8'h55, 3'b001, 4'd6},
    {2'd0, 15'h5555, 8'h20, 3'b001, 4'd6},
    {2'd1, 15'h0000, 8'h00, 3'b000, 4'd6},
    {2'd0, 15'h0300, 8'h01, 3'b100, 4'd6},
    {2'd2, 15'h0000, 8'h00, 3'b000, 4'd7},
    {2'd0, 15'h5555, 8'hAA, 3'b000, 4'd7},
    {2'd0, 15'h2AAA, 8'h56, 3'b100, 4'd7},  // R7 mismatch, unprotected
    {2'd2, 15'h0000, 8'h00, 3'b000, 4'd7}
  };

  task automatic chk(input int req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d,
                    input logic ea, input logic ed, input int req);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    #1;
    chk(req, "wr_accept", wr_accept, ea);
    chk(req, "dummy_start", dummy_start, ed);
    @(posedge clk); #1;
    wr_stb = 1'b0;
  endtask

  task automatic prog(input logic ep, input int req);
    @(negedge clk);
    prog_done = 1'b1;
    @(posedge clk); #1;
    prog_done = 1'b0;
    chk(req, "prot_on", prot_on, ep);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic soft_pulse();
    @(negedge clk);
    soft_rst_n = 1'b0;
    @(posedge clk); #1;
    soft_rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    por_n = 1'b1;
    @(negedge clk);
    chk(1, "prot_on after reset", prot_on, 1'b0);        // R1
    chk(1, "wr_accept idle", wr_accept, 1'b0);           // R1
    chk(1, "dummy_start idle", dummy_start, 1'b0);       // R1

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      case (v[31:30])
        2'd0: begin
          wr(v[29:15], v[14:7], v[6], v[5], int'(v[3:0]));
          chk(int'(v[3:0]), "prot_on", prot_on, v[4]);
        end
        2'd1: prog(v[4], int'(v[3:0]));
        default: begin
          idle(GAP + 2);
          chk(int'(v[3:0]), "prot_on", prot_on, v[4]);
        end
      endcase
    end

    // R8 gap boundary: GAP cycles continues, GAP+1 aborts
    wr(15'h5555, 8'hAA, 1'b0, 1'b0, 8);
    idle(GAP - 1);
    wr(15'h2AAA, 8'h55, 1'b0, 1'b0, 8);   // R8 still in sequence
    idle(GAP);
    wr(15'h5555, 8'hA0, 1'b1, 1'b0, 8);   // R8 aborted, plain write
    prog(1'b0, 10);                       // R10 nothing pending
    idle(GAP + 2);

    // R9 soft reset clears tracker only
    wr(15'h5555, 8'hAA, 1'b0, 1'b0, 3);
    wr(15'h2AAA, 8'h55, 1'b0, 1'b0, 3);
    wr(15'h5555, 8'hA0, 1'b0, 1'b0, 3);
    prog(1'b1, 3);
    idle(GAP + 2);
    wr(15'h5555, 8'hAA, 1'b0, 1'b0, 9);
    wr(15'h2AAA, 8'h55, 1'b0, 1'b0, 9);
    soft_pulse();
    chk(9, "prot_on after soft reset", prot_on, 1'b1);       // R9
    wr(15'h5555, 8'hA0, 1'b0, 1'b1, 9);                       // R9 tracker idle
    wr(15'h5555, 8'hAA, 1'b0, 1'b0, 6);
    wr(15'h2AAA, 8'h55, 1'b0, 1'b0, 6);
    wr(15'h5555, 8'h80, 1'b0, 1'b0, 6);
    wr(15'h5555, 8'hAA, 1'b0, 1'b0, 6);
    wr(15'h2AAA, 8'h55, 1'b0, 1'b0, 6);
    wr(15'h5555, 8'h20, 1'b0, 1'b0, 6);
    soft_pulse();
    chk(9, "prot_on before commit", prot_on, 1'b1);          // R9
    wr(15'h0400, 8'h09, 1'b0, 1'b1, 9);                       // R9 window closed
    prog(1'b0, 9);                                            // R9 pending kept
    wr(15'h0400, 8'h0A, 1'b1, 1'b0, 2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule